// File: doc/BRIEF.md
# Message-Based Barrier Coordinator

This block manages barrier synchronization for a tiled multicore in which cores coordinate by exchanging messages rather than by polling a shared variable in memory. Each participating core sends one barrier request that carries its own core ID, then stalls until it gets an addressed resume reply. The coordinator records arrivals in a per-core bitmap. It releases no core until every configured participant has checked in.

Once the final participant arrives, the coordinator enters a release phase. In that phase it issues one resume reply per arrived core, one per cycle, in ascending core-ID order. The replies leave on a reply channel that is separate from the request channel. While releases are in progress the request port is held off. When the last reply has gone, the bitmap and the arrival count clear and a one-cycle done pulse is raised. A duplicate request, or a request from a core outside the participant range, raises an error pulse and is not counted.

The participants are the cores with IDs 0 up to `part_count`-1. `part_count` is a configuration input that is held stable while a barrier is open.

Top module: `bar_coord`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `done` and `req_err` are 0.
- R2: While gathering, `req_ready` is 1. A request from a core with ID below `part_count` whose arrival bit is clear is accepted in one cycle and sets that bit.
- R3: No reply is offered until requests from all `part_count` participants have been accepted, in any order. The first reply is valid in the cycle after the completing request is accepted.
- R4: Exactly one reply goes to each participant, in ascending ID order (lowest set arrival bit first). Each reply is addressed only to an arrived core. With `rsp_ready` high, one reply is sent per cycle.
- R5: Every reply carries `rsp_word` equal to the parameter `RESUME_WORD` (default 16'h00C5).
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_dst` and `rsp_word` hold stable.
- R7: A request from a core whose arrival bit is already set raises `req_err` for exactly the one cycle after it is accepted. It is not counted again.
- R8: A request from a core with ID at or above `part_count` raises `req_err` in the same way and is not counted.
- R9: During the release phase `req_ready` is 0, and a pending request waits until the release phase ends.
- R10: In the cycle after the last reply handshake, `done` is 1 for one cycle, `rsp_valid` is 0 and `req_ready` is 1. The coordinator is then empty, so a new barrier starts from zero arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_count | input | CNT_W | Number of participants (IDs 0..part_count-1) |
| req_valid | input | 1 | Barrier request present |
| req_ready | output | 1 | Coordinator accepts requests (gathering) |
| req_src | input | ID_W | Core ID of the requester |
| rsp_valid | output | 1 | Resume reply present |
| rsp_ready | input | 1 | Reply channel accepts the reply |
| rsp_dst | output | ID_W | Core ID the reply is addressed to |
| rsp_word | output | WORD_W | Reply payload (resume code) |
| req_err | output | 1 | One-cycle pulse for a duplicate or out-of-range request |
| done | output | 1 | One-cycle pulse after the final reply |

## Verification
A request accepted at one rising edge shows its result on the following cycle. The error pulse and the release phase are visible one cycle after acceptance, each reply advances one cycle after its handshake, and `done` appears one cycle after the last reply handshake. The bench drives and samples on falling edges, so every check reads a state that has settled after exactly the number of rising edges stated in the requirement. It sweeps every participant count of a four-core build, every arrival order for the full set, and several back-pressure patterns on the reply channel, and computes the expected reply order from the participant count.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic {
    PH_GATHER  = 1'b0,
    PH_RELEASE = 1'b1
  } phase_t;

  localparam int unsigned MAP_MAX = 64;

  // index of the lowest set bit among the first n bits; 0 when none
  function automatic int unsigned lowest_set(input logic [MAP_MAX-1:0] m,
                                             input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = MAP_MAX - 1; i >= 0; i--) begin
      if (i < int'(n) && m[i]) r = i;
    end
    return r;
  endfunction

  // true when a core ID belongs to the participant range
  function automatic logic is_member(input int unsigned id,
                                     input int unsigned cnt);
    return id < cnt;
  endfunction

  // true when exactly one bit of the first n bits is set
  function automatic logic single_bit(input logic [MAP_MAX-1:0] m,
                                      input int unsigned n);
    int unsigned c;
    c = 0;
    for (int i = 0; i < MAP_MAX; i++) begin
      if (i < int'(n) && m[i]) c++;
    end
    return c == 1;
  endfunction

endpackage

// File: rtl/bar_arrival_map.sv
module bar_arrival_map #(
  parameter int NCORES = 8,
  localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int CNT_W = $clog2(NCORES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ID_W-1:0]   set_idx,
  input  logic              clr_en,
  input  logic [ID_W-1:0]   clr_idx,
  input  logic              flush,
  output logic [NCORES-1:0] map,
  output logic [CNT_W-1:0]  arrivals
);

  genvar g;
  generate
    for (g = 0; g < NCORES; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
          map[g] <= 1'b0;
        end else if (set_en && set_idx == ID_W'(g)) begin
          map[g] <= 1'b1;
        end else if (clr_en && clr_idx == ID_W'(g)) begin
          map[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      arrivals <= '0;
    end else if (set_en) begin
      arrivals <= arrivals + CNT_W'(1);
    end
  end

  // R7
  no_double_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !map[set_idx]);

  // R2
  count_tracks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush) |=> arrivals == $past(arrivals) + CNT_W'(1));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (map == '0 && arrivals == '0));

endmodule

// File: rtl/bar_release_pick.sv
module bar_release_pick #(
  parameter int NCORES = 8,
  localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic [NCORES-1:0] map,
  output logic [ID_W-1:0]   pick_idx,
  output logic              pick_any,
  output logic              pick_last
);
  import bar_pkg::*;

  logic [MAP_MAX-1:0] wide_map;

  always_comb begin
    wide_map = '0;
    wide_map[NCORES-1:0] = map;
    pick_idx  = ID_W'(lowest_set(wide_map, NCORES));
    pick_any  = |map;
    pick_last = single_bit(wide_map, NCORES);
  end

endmodule

// File: rtl/bar_coord.sv
module bar_coord #(
  parameter int          NCORES      = 8,
  parameter int          WORD_W      = 16,
  parameter logic [15:0] RESUME_WORD = 16'h00C5,
  localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int CNT_W = $clog2(NCORES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  part_count,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_src,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [WORD_W-1:0] rsp_word,
  output logic              req_err,
  output logic              done
);
  import bar_pkg::*;

  phase_t            phase_q;
  logic [NCORES-1:0] map_q;
  logic [CNT_W-1:0]  arrivals_q;
  logic [ID_W-1:0]   pick_idx;
  logic              pick_any;
  logic              pick_last;

  // named internal events
  logic accept_evt;
  logic legal_evt;
  logic bad_evt;
  logic complete_evt;
  logic send_evt;
  logic last_send_evt;
  logic already_set;

  always_comb begin
    req_ready     = (phase_q == PH_GATHER);
    accept_evt    = req_valid && req_ready;
    already_set   = is_member(int'(req_src), NCORES) ? map_q[req_src] : 1'b0;
    legal_evt     = accept_evt && is_member(int'(req_src), int'(part_count))
                    && !already_set;
    bad_evt       = accept_evt && !legal_evt;
    complete_evt  = legal_evt && (arrivals_q + CNT_W'(1) == part_count);
    rsp_valid     = (phase_q == PH_RELEASE) && pick_any;
    rsp_dst       = pick_idx;
    rsp_word      = WORD_W'(RESUME_WORD);
    send_evt      = rsp_valid && rsp_ready;
    last_send_evt = send_evt && pick_last;
  end

  bar_arrival_map #(.NCORES(NCORES)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (legal_evt),
    .set_idx  (req_src),
    .clr_en   (send_evt),
    .clr_idx  (pick_idx),
    .flush    (last_send_evt),
    .map      (map_q),
    .arrivals (arrivals_q)
  );

  bar_release_pick #(.NCORES(NCORES)) pick_i (
    .map       (map_q),
    .pick_idx  (pick_idx),
    .pick_any  (pick_any),
    .pick_last (pick_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_GATHER;
      req_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      req_err <= bad_evt;
      done    <= last_send_evt;
      if (phase_q == PH_GATHER && complete_evt) begin
        phase_q <= PH_RELEASE;
      end else if (phase_q == PH_RELEASE && last_send_evt) begin
        phase_q <= PH_GATHER;
      end
    end
  end

  // R3
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> arrivals_q == part_count);

  // R4
  reply_to_arrived_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> map_q[rsp_dst]);

  // R4
  ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (map_q & ((NCORES'(1) << rsp_dst) - NCORES'(1))) == '0);

  // R6
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dst) && $stable(rsp_word)));

  // R9
  no_accept_in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !accept_evt);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rsp_valid && req_ready));

  // R7
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err && !$past(bad_evt)) |-> 1'b0);

endmodule

// File: tb/bar_coord_tb_top.sv
module bar_coord_tb_top;

  localparam int NC    = 4;
  localparam int IDW   = 2;
  localparam int CW    = 3;
  localparam int WW    = 16;
  localparam logic [15:0] RW = 16'h00C5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [CW-1:0]  part_count = '0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [IDW-1:0] req_src = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b0;
  logic [IDW-1:0] rsp_dst;
  logic [WW-1:0]  rsp_word;
  logic           req_err;
  logic           done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bar_coord #(.NCORES(NC), .WORD_W(WW), .RESUME_WORD(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .part_count(part_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dst(rsp_dst),
    .rsp_word(rsp_word), .req_err(req_err), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive one request at a falling edge; return at the falling edge after acceptance
  task automatic send_req(input int src);
    req_valid = 1'b1;
    req_src   = IDW'(src);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // collect cnt replies with a stall pattern; ends one cycle after done was seen
  task automatic collect(input int cnt, input int seed);
    int got = 0;
    int k = 0;
    while (got < cnt && k < 64) begin
      rsp_ready = ((k + seed) % 3) != 1;
      chk(rsp_valid == 1'b1, "R3 reply valid", int'(rsp_valid), 1);
      chk(rsp_dst == IDW'(got), "R4 reply order", int'(rsp_dst), got);
      chk(rsp_word == RW, "R5 reply word", int'(rsp_word), int'(RW));
      chk(req_ready == 1'b0, "R9 ready low in release", int'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
      if (rsp_ready) got++;
      k++;
    end
    rsp_ready = 1'b0;
    chk(done == 1'b1, "R10 done pulse", int'(done), 1);
    chk(rsp_valid == 1'b0, "R10 no reply after last", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R10 ready restored", int'(req_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic run_order(input int cnt, input int o0, input int o1,
                           input int o2, input int o3, input int seed);
    int ord[4];
    ord[0] = o0; ord[1] = o1; ord[2] = o2; ord[3] = o3;
    part_count = CW'(cnt);
    for (int i = 0; i < cnt; i++) begin
      chk(req_ready == 1'b1, "R2 ready while gathering", int'(req_ready), 1);
      send_req(ord[i]);
      chk(req_err == 1'b0, "R2 legal request no error", int'(req_err), 0);
      if (i < cnt - 1)
        chk(rsp_valid == 1'b0, "R3 no early reply", int'(rsp_valid), 0);
    end
    collect(cnt, seed);
  endtask

  initial begin : watchdog
    wait (cyc >= 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(req_err == 1'b0, "R1 reset err", int'(req_err), 0);

    // small counts, rotated arrival orders
    for (int c = 1; c <= 3; c++) begin
      for (int r = 0; r < c; r++) begin
        run_order(c, (r) % c, (r + 1) % c, (r + 2) % c, 0, r + c);
      end
    end

    // full set: every arrival order of four cores
    begin
      int n = 0;
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++)
              if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                run_order(4, a, b, c, d, n);
                n++;
              end
    end

    // R7 duplicate request is flagged and not counted
    part_count = CW'(2);
    send_req(1);
    send_req(1);
    chk(req_err == 1'b1, "R7 duplicate flagged", int'(req_err), 1);
    chk(rsp_valid == 1'b0, "R7 duplicate not counted", int'(rsp_valid), 0);
    @(negedge clk);
    chk(req_err == 1'b0, "R7 error one cycle", int'(req_err), 0);
    send_req(0);
    chk(req_err == 1'b0, "R7 legal after dup", int'(req_err), 0);
    collect(2, 0);

    // R8 out-of-range ID is flagged and not counted
    part_count = CW'(3);
    send_req(3);
    chk(req_err == 1'b1, "R8 out-of-range flagged", int'(req_err), 1);
    send_req(0);
    send_req(2);
    chk(rsp_valid == 1'b0, "R8 out-of-range not counted", int'(rsp_valid), 0);
    send_req(1);
    collect(3, 2);

    // R9 request held during release, accepted when the phase ends
    part_count = CW'(1);
    send_req(0);
    chk(rsp_valid == 1'b1, "R3 single participant release", int'(rsp_valid), 1);
    req_valid = 1'b1;
    req_src   = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 held off", int'(req_ready), 0);
    chk(req_err == 1'b0, "R9 held request not flagged", int'(req_err), 0);
    chk(rsp_valid == 1'b1, "R6 reply holds under stall", int'(rsp_valid), 1);
    chk(rsp_dst == 2'd0, "R6 reply dst holds", int'(rsp_dst), 0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(done == 1'b1, "R10 done after release", int'(done), 1);
    chk(req_ready == 1'b1, "R10 ready with done", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9 held request starts new barrier", int'(rsp_valid), 1);
    chk(done == 1'b0, "R10 done cleared", int'(done), 0);
    collect(1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule